// File: doc/BRIEF.md
# Load-Clock Divider Controller with Serial Configuration

This block runs from a fast pixel clock. It produces three outputs: a complementary clock pair at half the input rate, and a load strobe (LD) whose rate is the input rate divided by a programmable ratio. A 12-bit control word selects the ratio and a few run controls. The word is shifted in over a three-wire serial port (data, shift clock and latch strobe), and the port's pins are sampled in the pixel-clock domain.

The control word has these fields:
- A 3-bit ratio code in bits 0 to 2, which picks one of six ratios through a non-linear table.
- A reserved bit 3, which always reads as zero.
- A one-way lockout in bit 4.
- A counter-reset in bit 5.
- An output-hold in bit 6.
- A blank-gating enable in bit 9.
- Bits 7, 8, 10 and 11, which are stored and read back but have no effect.

The ratio table is 000→3, 001→4, 010→4, 011→5, 100→6, 101→8, 110→8, 111→10. Ratio changes are applied only where LD rises, so no short pulse is produced. A held clock pair restarts in step with LD. Once the lockout bit is latched, the block goes quiet until a full reset.

Top module: `ldclk_divctl`

## Requirements
- R1: LD has a period of N input cycles. It is high for floor(N/2) cycles and low for the rest. N comes from the ratio code in bits 2:0 through the table 000→3, 001→4, 010→4, 011→5, 100→6, 101→8, 110→8, 111→10.
- R2: After reset the control word reads 12'h001, which selects divide-by-four, and LD starts toggling at that ratio.
- R3: Bit 3 of the control word always reads back as 0, even if a 1 is shifted into it.
- R4: While bit 6 (output hold) is 1, clk_p_o is high and clk_n_o is low. LD keeps running during this time.
- R5: When bit 6 returns to 0, the pair stays held until the next rising edge of LD. At that same clock edge clk_p_o goes low, and toggling continues from there.
- R6: While bit 9 is 1 and blank_i is high, LD is held low and the divider keeps counting. While bit 9 is 0, blank_i has no effect.
- R7: While bit 5 (counter reset) is 1, the divider is held and LD stays low. After bit 5 is cleared, LD rises within two cycles and runs at the selected ratio.
- R8: Latching a word with bit 4 set locks the block. LD then stays low, the pair is held, and every later load is ignored until rst_n is asserted.
- R9: A new ratio code takes effect only at an LD rising edge, so every LD high pulse and every period matches either the old ratio or the new one.
- R10: Outside hold and lockout, clk_p_o toggles every input cycle and clk_n_o is its complement.
- R11: Bits are shifted in least significant first on rising edges of ser_clk_i. The shifted word becomes the control word at the rising edge of ser_load_i, and cfg_o reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data_i | input | 1 | Serial data bit |
| ser_clk_i | input | 1 | Serial shift clock, sampled by clk |
| ser_load_i | input | 1 | Latch strobe, rising edge loads the word |
| blank_i | input | 1 | Blanking input that can gate LD |
| clk_p_o | output | 1 | Positive clock output |
| clk_n_o | output | 1 | Negative clock output |
| ld_o | output | 1 | Divided load clock |
| cfg_o | output | 12 | Current control word |

## Verification
The assertions assume that the serial pins are synchronous to clk. They also assume that ser_clk_i and ser_load_i never rise in the same cycle, and that each level is held for several pixel cycles so that every edge is seen exactly once. The bench drives every serial phase for three cycles, on the falling clock edge. It raises the strobe only after the twelfth shift, and it changes blank_i only at falling edges. Random control words are masked so that the lockout bit is set only in the directed lockout case.

// File: rtl/ldclk_pkg.sv
package ldclk_pkg;
    localparam int REG_W  = 12;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 4;

    // control word bit positions
    localparam int B_RSV  = 3;
    localparam int B_LOCK = 4;
    localparam int B_CRST = 5;
    localparam int B_HOLD = 6;
    localparam int B_GATE = 9;

    localparam logic [REG_W-1:0] CFG_RESET = 12'h001;

    // non-linear ratio code to divide ratio
    function automatic logic [CNT_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            3'd0:    r = CNT_W'(3);
            3'd1:    r = CNT_W'(4);
            3'd2:    r = CNT_W'(4);
            3'd3:    r = CNT_W'(5);
            3'd4:    r = CNT_W'(6);
            3'd5:    r = CNT_W'(8);
            3'd6:    r = CNT_W'(8);
            default: r = CNT_W'(10);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ldclk_ser_cfg.sv
module ldclk_ser_cfg
    import ldclk_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdat_i,
    input  logic         sclk_i,
    input  logic         sload_i,
    output logic [W-1:0] cfg_o,
    output logic         locked_o
);
    typedef struct packed {
        logic         sclk;
        logic         sload;
        logic [W-1:0] sh;
        logic [W-1:0] cfg;
        logic         locked;
    } st_t;

    st_t st_d, st_q;
    logic shift_ev, load_ev;

    always_comb begin
        st_d       = st_q;
        st_d.sclk  = sclk_i;
        st_d.sload = sload_i;
        shift_ev   = sclk_i & ~st_q.sclk & ~st_q.locked;
        load_ev    = sload_i & ~st_q.sload & ~st_q.locked;
        if (shift_ev) begin
            st_d.sh = {sdat_i, st_q.sh[W-1:1]};
        end
        if (load_ev) begin
            st_d.cfg        = st_q.sh;
            st_d.cfg[B_RSV] = 1'b0;
            st_d.locked     = st_q.sh[B_LOCK];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sclk   <= 1'b0;
            st_q.sload  <= 1'b0;
            st_q.sh     <= '0;
            st_q.cfg    <= W'(CFG_RESET);
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o    = st_q.cfg;
    assign locked_o = st_q.locked;

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.cfg));
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> st_q.locked);
    a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        load_ev |=> (cfg_o[B_RSV] == 1'b0));
    a_r11_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ev && !st_q.sh[B_RSV]) |=> (cfg_o == $past(st_q.sh)));
endmodule

// File: rtl/ldclk_ratio_div.sv
module ldclk_ratio_div
    import ldclk_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] code_i,
    input  logic          crst_i,
    input  logic          gate_en_i,
    input  logic          blank_i,
    input  logic          locked_i,
    output logic          ld_o,
    output logic          ld_rise_o
);
    localparam logic [NW-1:0] RST_N = NW'(4);

    typedef struct packed {
        logic [NW-1:0] cnt;
        logic [NW-1:0] n;
        logic          ld;
    } st_t;

    st_t st_d, st_q;
    logic [NW-1:0] nsel, hi;
    logic          wrap, gated;

    always_comb begin
        st_d  = st_q;
        nsel  = ratio_of(code_i);
        wrap  = (st_q.cnt == st_q.n - 1'b1);
        gated = gate_en_i & blank_i;
        if (crst_i) begin
            st_d.n   = nsel;
            st_d.cnt = nsel - 1'b1;
        end else if (wrap) begin
            st_d.n   = nsel;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        hi        = st_d.n >> 1;
        st_d.ld   = (st_d.cnt < hi) & ~crst_i & ~gated & ~locked_i;
        ld_rise_o = st_d.ld & ~st_q.ld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= RST_N - 1'b1;
            st_q.n   <= RST_N;
            st_q.ld  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_o = st_q.ld;

    a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.n);
    a_r9_n_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!crst_i && st_q.cnt != st_q.n - 1'b1) |=> $stable(st_q.n));
    a_r6_blank_low: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_i && blank_i) |=> !ld_o);
    a_r7_crst_low: assert property (@(posedge clk) disable iff (!rst_n)
        crst_i |=> !ld_o);
endmodule

// File: rtl/ldclk_pair.sv
module ldclk_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic ld_rise_i,
    output logic clk_p_o,
    output logic clk_n_o
);
    typedef struct packed {
        logic run;
        logic tog;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = ~hold_i & (st_q.run | ld_rise_i);
        st_d.tog = st_d.run ? ~st_q.tog : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run <= 1'b1;
            st_q.tog <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_p_o = st_q.tog;
    assign clk_n_o = ~st_q.tog;

    a_r4_hold_levels: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (clk_p_o && !clk_n_o));
    a_r5_wait_for_ld: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !ld_rise_i) |=> (!st_q.run && clk_p_o));
    a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !hold_i) |=> (clk_p_o != $past(clk_p_o)));
endmodule

// File: rtl/ldclk_divctl.sv
module ldclk_divctl
    import ldclk_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int CW = CODE_W,
    parameter int NW = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_data_i,
    input  logic         ser_clk_i,
    input  logic         ser_load_i,
    input  logic         blank_i,
    output logic         clk_p_o,
    output logic         clk_n_o,
    output logic         ld_o,
    output logic [W-1:0] cfg_o
);
    logic [W-1:0] cfg;
    logic         locked, ld_rise, hold_eff;

    ldclk_ser_cfg #(.W(W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdat_i   (ser_data_i),
        .sclk_i   (ser_clk_i),
        .sload_i  (ser_load_i),
        .cfg_o    (cfg),
        .locked_o (locked)
    );

    ldclk_ratio_div #(.CW(CW), .NW(NW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_i    (cfg[CW-1:0]),
        .crst_i    (cfg[B_CRST]),
        .gate_en_i (cfg[B_GATE]),
        .blank_i   (blank_i),
        .locked_i  (locked),
        .ld_o      (ld_o),
        .ld_rise_o (ld_rise)
    );

    assign hold_eff = cfg[B_HOLD] | locked;

    ldclk_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (hold_eff),
        .ld_rise_i (ld_rise),
        .clk_p_o   (clk_p_o),
        .clk_n_o   (clk_n_o)
    );

    assign cfg_o = cfg;

    a_r8_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (!ld_o && clk_p_o && !clk_n_o));
endmodule

// File: tb/ldclk_divctl_tb.sv
`timescale 1ns/1ps
module ldclk_divctl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdat = 1'b0, sclk = 1'b0, sload = 1'b0, blank = 1'b0;
    logic clk_p, clk_n, ld;
    logic [11:0] cfg;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ldclk_divctl dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data_i(sdat), .ser_clk_i(sclk),
        .ser_load_i(sload), .blank_i(blank), .clk_p_o(clk_p),
        .clk_n_o(clk_n), .ld_o(ld), .cfg_o(cfg)
    );

    function automatic int exp_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 3;
            3'd1: return 4;
            3'd2: return 4;
            3'd3: return 5;
            3'd4: return 6;
            3'd5: return 8;
            3'd6: return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic [11:0] mk(input logic [2:0] c, input logic hold,
                                       input logic crst, input logic gate, input logic lock);
        logic [11:0] v = 12'h0;
        v[2:0] = c; v[6] = hold; v[5] = crst; v[9] = gate; v[4] = lock;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_word(input logic [11:0] v);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); sdat = v[i]; sclk = 1'b0;
            tick(2);
            @(negedge clk); sclk = 1'b1;
            tick(2);
        end
        @(negedge clk); sclk = 1'b0;
        tick(2);
    endtask

    task automatic strobe();
        @(negedge clk); sload = 1'b1;
        tick(3);
        @(negedge clk); sload = 1'b0;
        tick(2);
    endtask

    task automatic load(input logic [11:0] v);
        shift_word(v);
        strobe();
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev = ld;
        hi = 0; lo = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!prev && ld) break;
            prev = ld;
        end
        hi = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ld) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!ld) lo++; else break;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int hi, lo, n, rises;
        logic [11:0] v;
        logic prev;
        void'($urandom(32'h5eed1572));
        tick(4);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R2: reset word and divide-by-four
        chk(cfg == 12'h001, "R2 reset cfg", cfg, 12'h001);
        measure(hi, lo);
        chk(hi == 2 && lo == 2, "R2 reset ratio", hi + lo, 4);
        // R10: free-running pair
        for (int i = 0; i < 4; i++) begin
            prev = clk_p;
            @(negedge clk);
            chk(clk_p != prev && clk_n == ~clk_p, "R10 toggle", clk_p, !prev);
        end
        // R1: every ratio code
        for (int c = 0; c < 8; c++) begin
            load(mk(3'(c), 0, 0, 0, 0));
            measure(hi, lo); measure(hi, lo);
            n = exp_ratio(3'(c));
            chk(hi + lo == n, "R1 period", hi + lo, n);
            chk(hi == n / 2, "R1 high time", hi, n / 2);
        end
        // R11/R3: random words read back, reserved bit cleared
        for (int i = 0; i < 10; i++) begin
            v = 12'($urandom()) & ~12'h070;
            load(v);
            chk(cfg == (v & ~12'h008), "R11 readback", cfg, v & ~12'h008);
            chk(cfg[3] == 1'b0, "R3 reserved zero", cfg[3], 0);
            if (v[9] == 1'b0) begin
                measure(hi, lo); measure(hi, lo);
                n = exp_ratio(v[2:0]);
                chk(hi + lo == n, "R1 random period", hi + lo, n);
            end
        end
        load(12'h00B);
        chk(cfg == 12'h003, "R3 reserved written one", cfg, 12'h003);
        // R4: hold forces levels, LD keeps running
        load(mk(3'd5, 1, 0, 0, 0));
        rises = 0; prev = ld;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (!prev && ld) rises++;
            prev = ld;
            if (i % 6 == 0) chk(clk_p && !clk_n, "R4 hold levels", clk_p, 1);
        end
        chk(rises == 3, "R4 LD runs in hold", rises, 3);
        // R5: resume on LD rise
        shift_word(mk(3'd5, 0, 0, 0, 0));
        @(negedge clk); sload = 1'b1;
        @(negedge clk);
        prev = ld;
        chk(clk_p == 1'b1, "R5 still held", clk_p, 1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!prev && ld) begin
                chk(clk_p == 1'b0, "R5 first toggle at LD rise", clk_p, 0);
                @(negedge clk);
                chk(clk_p == 1'b1, "R5 second toggle", clk_p, 1);
                break;
            end
            chk(clk_p == 1'b1, "R5 held before LD rise", clk_p, 1);
            prev = ld;
        end
        sload = 1'b0;
        tick(3);
        // R6: blank gating
        load(mk(3'd4, 0, 0, 1, 0));
        @(negedge clk); blank = 1'b1;
        @(negedge clk);
        rises = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ld) rises++;
        end
        chk(rises == 0, "R6 blank holds LD low", rises, 0);
        @(negedge clk); blank = 1'b0;
        measure(hi, lo); measure(hi, lo);
        chk(hi + lo == 6 && hi == 3, "R6 ratio after blank", hi + lo, 6);
        load(mk(3'd4, 0, 0, 0, 0));
        @(negedge clk); blank = 1'b1;
        measure(hi, lo); measure(hi, lo);
        chk(hi + lo == 6, "R6 blank ignored when disabled", hi + lo, 6);
        @(negedge clk); blank = 1'b0;
        // R7: counter reset
        load(mk(3'd3, 0, 1, 0, 0));
        rises = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ld) rises++;
        end
        chk(rises == 0, "R7 LD low in counter reset", rises, 0);
        shift_word(mk(3'd3, 0, 0, 0, 0));
        @(negedge clk); sload = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ld == 1'b1, "R7 LD rises after release", ld, 1);
        sload = 1'b0;
        measure(hi, lo);
        chk(hi + lo == 5 && hi == 2, "R7 ratio after release", hi + lo, 5);
        // R9: ratio change mid-period, no runts
        load(mk(3'd0, 0, 0, 0, 0));
        shift_word(mk(3'd7, 0, 0, 0, 0));
        @(negedge clk); sload = 1'b1;
        for (int i = 0; i < 5; i++) begin
            measure(hi, lo);
            if (i == 0) sload = 1'b0;
            chk((hi == 1 && hi + lo == 3) || (hi == 5 && hi + lo == 10),
                "R9 no runt", hi * 100 + hi + lo, 510);
        end
        chk(hi + lo == 10, "R9 new ratio applied", hi + lo, 10);
        // R8: lockout
        load(mk(3'd1, 0, 0, 0, 1));
        v = cfg;
        rises = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ld || !clk_p || clk_n) rises++;
        end
        chk(rises == 0, "R8 quiet when locked", rises, 0);
        load(12'h005);
        chk(cfg == v, "R8 load ignored", cfg, v);
        @(negedge clk); rst_n = 1'b0;
        tick(2);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(cfg == 12'h001, "R8 reset clears lock", cfg, 12'h001);
        measure(hi, lo);
        chk(hi + lo == 4, "R8 runs after reset", hi + lo, 4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule